// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-driven MDIO master for PHY management. A host sees two 16-bit registers. The data register holds write data before a transaction and the PHY's answer after one. The control register takes a packed command word. Writing the command word while the engine is idle starts one management frame toward the PHY, either a read or a write. The engine divides the system clock down to MDC and shifts the frame out on MDIO. On reads it releases the line and samples the PHY's reply into the data register.

The host writes the data register first if it is issuing a write, then writes the command word. It then polls the finished flag in the control readback until the flag returns high. Command writes that arrive while a frame is in flight are dropped. Only the frame already running reaches the pins.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, control readback bit 15 (finished) is 1, the data register reads 0, MDC is low and the MDIO output enable is low. The output enable stays low whenever no transaction is running.
- R2: A write with `host_sel`=1 (control register) while idle starts a transaction. From the next clock edge until the transaction ends, the finished flag reads 0.
- R3: Every frame is 64 bits sent MSB first: 32 ones of preamble, start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, the 5-bit PHY address and then the 5-bit register number. Each bit is held on `mdio_o` across one MDC rising edge.
- R4: In a write frame, turnaround bits 1,0 follow the address fields, then the 16 bits of the data register. The output enable is high for all 64 bits, and the data register keeps its value.
- R5: In a read frame, the output enable is high only for the first 46 bits and is low for the turnaround and the 16 data bits. `mdio_i` is sampled at the MDC rising edge of each of the last 16 bits, MSB first, and the result is stored in the data register when the frame ends.
- R6: MDC is low while idle and has a period of 2*DIV_HALF system clock cycles during a frame. `mdio_o` and the output enable change only when MDC falls, never while MDC stays high.
- R7: A control-register write while a transaction runs is ignored. The running frame is unchanged, the command readback keeps the old fields, and no further frame follows.
- R8: Control readback puts the finished flag at bit 15, the write flag at bit 13, the PHY address at [12:8] and the register number at [4:0], and all other bits read 0. A command word written with `host_sel`=1 uses the same field positions (bit 13 set means write).
- R9: A transaction lasts exactly 128*DIV_HALF system clock cycles. The count runs from the edge that accepts the command to the edge after which the finished flag reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Write target: 1 = control register, 0 = data register |
| host_wdata | input | 16 | Host write data |
| host_rsel | input | 1 | Read select: 1 = control readback, 0 = data register |
| host_rdata | output | 16 | Read data for the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data returned by the PHY |

## Verification
The bench builds the engine with DIV_HALF=3. An odd half period makes the divider wrap at a value that is not a power of two, and it still keeps each transaction short at 384 cycles. That short length allows a run of writes and reads with all-zero and all-one address fields. It also allows read data whose first and last bits are set, plus a command write that lands in the middle of a running read. A responder in the bench drives the reply bits between MDC rising edges. This checks the rising-edge capture point and the release of the line during turnaround.

// File: rtl/mgmt_pkg.sv
// Shared constants, command type and frame builder for the MDIO command engine.
// Assumes clause-22 framing with a full preamble on every frame.
package mgmt_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = PRE_BITS + 2 + 2 + 2 * ADDR_W;   // bits before turnaround
    localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;          // 64
    localparam int DATA_POS   = HDR_BITS + 2;                   // first data bit index

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    // Control word field positions
    localparam int WR_BIT  = 13;
    localparam int PHY_LSB = 8;
    localparam int REG_LSB = 0;
    localparam int FIN_BIT = 15;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
    } mgmt_cmd_t;

    // Assemble the full serial frame, MSB transmitted first
    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c, logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] pay;
        op  = c.is_wr ? OP_WRITE : OP_READ;
        ta  = c.is_wr ? TA_DRIVE : 2'b11;
        pay = c.is_wr ? d : {DATA_W{1'b1}};
        return {{PRE_BITS{1'b1}}, SOF_BITS, op, c.phy, c.regn, ta, pay};
    endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
// MDC generator: divides clk by 2*DIV_HALF while enabled and flags the system
// cycle in which MDC will rise or fall at the next edge.
// Assumes en is held for a whole frame; MDC is forced low when en drops.
module mgmt_mdc_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    // Choose the tick source: every cycle for DIV_HALF of 1, else on counter wrap
    generate
        if (DIV_HALF == 1) begin : g_every
            assign tick = en;
        end else begin : g_count
            assign tick = en && (cnt_q == LAST);
        end
    endgenerate

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc      = mdc_q;
    assign rise_stb = tick && !mdc_q;
    assign fall_stb = tick &&  mdc_q;

endmodule

// File: rtl/mgmt_frame_engine.sv
// Frame sequencer: loads a 64-bit frame on start, shifts it out one bit per
// MDC falling edge, releases the line for read turnaround and data, and
// captures read data on MDC rising edges.
// Assumes start only arrives while idle and strobes come from mgmt_mdc_gen.
module mgmt_frame_engine
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_IDX  = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] LAST_DRV  = IW'(HDR_BITS - 1);
    localparam logic [IW-1:0] FIRST_DAT = IW'(DATA_POS);

    logic [FRAME_BITS-1:0] sh_q;
    logic [IW-1:0]         idx_q;
    logic                  busy_q;
    logic                  is_wr_q;
    logic                  o_q;
    logic                  oe_q;
    logic [DATA_W-1:0]     cap_q;
    logic                  last_fall;
    logic [FRAME_BITS-1:0] frame;

    assign frame     = build_frame(cmd, wdata);
    assign last_fall = busy_q && fall_stb && (idx_q == LAST_IDX);

    // Frame load, bit advance on MDC fall, and line release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            sh_q    <= '0;
            o_q     <= 1'b1;
            oe_q    <= 1'b0;
            is_wr_q <= 1'b0;
        end else if (start) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            sh_q    <= frame;
            o_q     <= frame[FRAME_BITS-1];
            oe_q    <= 1'b1;
            is_wr_q <= cmd.is_wr;
        end else if (busy_q && fall_stb) begin
            if (last_fall) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
                o_q    <= 1'b1;
                oe_q   <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                o_q   <= sh_q[FRAME_BITS-2];
                oe_q  <= is_wr_q || (idx_q < LAST_DRV);
            end
        end
    end

    // Read-data capture on MDC rising edges of the data bits
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cap_q <= '0;
        end else if (busy_q && rise_stb && !is_wr_q && (idx_q >= FIRST_DAT)) begin
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        end
    end

    assign busy     = busy_q;
    assign mdio_o   = o_q;
    assign mdio_oe  = oe_q;
    assign rd_done  = last_fall && !is_wr_q;
    assign rd_value = cap_q;

endmodule

// File: rtl/mgmt_host_regs.sv
// Host register pair: decodes command writes, gates launch on idle, holds the
// data register and forms readback. Assumes single-cycle host strobes.
module mgmt_host_regs
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [15:0]       host_wdata,
    input  logic              host_rsel,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_value,
    output logic [15:0]       host_rdata,
    output logic              launch,
    output mgmt_cmd_t         new_cmd,
    output mgmt_cmd_t         cmd_q,
    output logic [DATA_W-1:0] data_q
);
    logic unused_bits;

    assign unused_bits   = ^{host_wdata[15:14], host_wdata[7:5]};
    assign new_cmd.is_wr = host_wdata[WR_BIT];
    assign new_cmd.phy   = host_wdata[PHY_LSB +: ADDR_W];
    assign new_cmd.regn  = host_wdata[REG_LSB +: ADDR_W];
    assign launch        = host_wr && host_sel && !busy;

    // Latch the accepted command for readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (launch) begin
            cmd_q <= new_cmd;
        end
    end

    // Data register: read completion wins over a host write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_value;
        end else if (host_wr && !host_sel) begin
            data_q <= host_wdata;
        end
    end

    // Readback mux
    always_comb begin
        host_rdata = '0;
        if (host_rsel) begin
            host_rdata[FIN_BIT]                = !busy;
            host_rdata[WR_BIT]                 = cmd_q.is_wr;
            host_rdata[PHY_LSB +: ADDR_W]      = cmd_q.phy;
            host_rdata[REG_LSB +: ADDR_W]      = cmd_q.regn;
        end else begin
            host_rdata = data_q;
        end
    end

endmodule

// File: rtl/mgmt_serial_master.sv
// Top of the MDIO command engine: host registers, frame sequencer and MDC
// divider. Assumes the host polls the finished flag between commands.
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    input  logic        host_rsel,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              eng_busy;
    logic              launch;
    logic              rise_stb;
    logic              fall_stb;
    logic              rd_done;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] data_q;
    mgmt_cmd_t         new_cmd;
    mgmt_cmd_t         cmd_q;

    mgmt_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rsel  (host_rsel),
        .busy       (eng_busy),
        .rd_done    (rd_done),
        .rd_value   (rd_value),
        .host_rdata (host_rdata),
        .launch     (launch),
        .new_cmd    (new_cmd),
        .cmd_q      (cmd_q),
        .data_q     (data_q)
    );

    mgmt_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (eng_busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mgmt_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .cmd      (new_cmd),
        .wdata    (data_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_value (rd_value)
    );

endmodule

// File: rtl/mgmt_serial_master_chk.sv
// Protocol checker for mgmt_serial_master, attached by bind below.
module mgmt_serial_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_sel,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [10:0] cmd_bits
);
    // A control write while idle must start a transaction
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && host_sel) |=> busy);

    // MDC rests low while idle
    assert_idle_mdc_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // Line outputs hold while MDC stays high
    assert_out_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // Command fields untouched by writes during a transaction
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_sel) |=> $stable(cmd_bits));

    // Pad released whenever idle
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

endmodule

bind mgmt_serial_master mgmt_serial_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (host_wr),
    .host_sel (host_sel),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (eng_busy),
    .cmd_bits (cmd_q)
);

// File: tb/mgmt_serial_master_bench.sv
module mgmt_serial_master_bench;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_rsel = 1'b1;
    logic [15:0] host_wdata = '0;
    logic        mdio_i = 1'b1;
    wire  [15:0] host_rdata;
    wire         mdc;
    wire         mdio_o;
    wire         mdio_oe;

    always #4 clk = ~clk;

    mgmt_serial_master #(.DIV_HALF(H)) u_mgmt_serial_master (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues filled by the driver, drained by the monitor
    logic [63:0] exp_bits_q[$];
    logic [63:0] exp_oe_q[$];

    int          rise_cnt = 0;
    int          since_rise = 0;
    int          frames_seen = 0;
    logic [15:0] phy_val = '0;
    logic [63:0] got_bits = '0;
    logic [63:0] got_oe = '0;
    logic        mdc_prev = 1'b0;
    logic        o_prev = 1'b1;
    logic        oe_prev = 1'b0;

    // Monitor and PHY responder, sampling away from the active edge
    always @(negedge clk) begin
        logic [63:0] eb;
        logic [63:0] eo;
        if (rst_n) begin
            since_rise++;
            if (mdc && mdc_prev && (mdio_o !== o_prev || mdio_oe !== oe_prev))
                check(1'b0, "R6", "line changed while MDC high", {62'b0, mdio_o, mdio_oe}, {62'b0, o_prev, oe_prev});
            if (mdc && !mdc_prev) begin
                if (rise_cnt > 0)
                    check(since_rise == 2 * H, "R6", "MDC period", since_rise, 2 * H);
                since_rise = 0;
                got_bits[63 - rise_cnt] = mdio_o;
                got_oe[63 - rise_cnt]   = mdio_oe;
                rise_cnt++;
                if (rise_cnt == 64) begin
                    rise_cnt = 0;
                    frames_seen++;
                    if (exp_bits_q.size() == 0) begin
                        check(1'b0, "R7", "unexpected frame", got_bits, '0);
                    end else begin
                        eb = exp_bits_q.pop_front();
                        eo = exp_oe_q.pop_front();
                        check((got_bits & eo) == (eb & eo), "R3", "frame bits", got_bits & eo, eb & eo);
                        check(got_oe == eo, "R5", "output enable pattern", got_oe, eo);
                    end
                end
            end
            mdio_i = (rise_cnt >= 48 && rise_cnt < 64) ? phy_val[63 - rise_cnt] : 1'b1;
        end
        mdc_prev = mdc;
        o_prev   = mdio_o;
        oe_prev  = mdio_oe;
    end

    task automatic host_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: queue the expected frame, launch, time and check the result
    task automatic run_cmd(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] val, input bit poke);
        int cycles;
        logic [63:0] eb;
        logic [63:0] eo;
        if (wr) host_write(1'b0, val);
        else    phy_val = val;
        eb = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
              (wr ? 2'b10 : 2'b00), (wr ? val : 16'h0000)};
        eo = wr ? {64{1'b1}} : {{46{1'b1}}, {18{1'b0}}};
        exp_bits_q.push_back(eb);
        exp_oe_q.push_back(eo);
        host_rsel = 1'b1;
        host_write(1'b1, {2'b00, wr, pa, 3'b000, ra});
        check(host_rdata[15] == 1'b0, "R2", "finished low after launch", host_rdata[15], 0);
        cycles = 0;
        if (poke) begin
            repeat (20) @(negedge clk);
            cycles += 20;
            host_write(1'b1, {2'b00, ~wr, ~pa, 3'b000, ~ra});
            cycles += 2;
        end
        while (host_rdata[15] == 1'b0 && cycles < 4000) begin
            @(negedge clk);
            cycles++;
        end
        check(cycles == 128 * H, "R9", "transaction length", cycles, 128 * H);
        check(mdc == 1'b0, "R6", "MDC low after finish", mdc, 0);
        check(host_rdata == {1'b1, 1'b0, wr, pa, 3'b000, ra},
              poke ? "R7" : "R8", "control readback", host_rdata, {1'b1, 1'b0, wr, pa, 3'b000, ra});
        host_rsel = 1'b0;
        #1;
        check(host_rdata == val, wr ? "R4" : "R5", "data register", host_rdata, val);
        host_rsel = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        host_rsel = 1'b1;
        #1;
        check(host_rdata == 16'h8000, "R1", "control readback at reset", host_rdata, 16'h8000);
        check(mdc == 1'b0, "R1", "MDC low at reset", mdc, 0);
        check(mdio_oe == 1'b0, "R1", "output enable low at reset", mdio_oe, 0);
        host_rsel = 1'b0;
        #1;
        check(host_rdata == 16'h0000, "R1", "data register at reset", host_rdata, 0);

        run_cmd(1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b0);   // R4 write
        run_cmd(1'b0, 5'h1F, 5'h1F, 16'h8001, 1'b0);   // R5 read, all-one fields
        run_cmd(1'b0, 5'h00, 5'h00, 16'h7FFE, 1'b1);   // R7 write during a read
        run_cmd(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b0);   // R4 zero data
        run_cmd(1'b0, 5'h0C, 5'h13, 16'h5A96, 1'b0);   // R5 mixed data

        // R7 no extra frame afterwards, R1 line released while idle
        seen = frames_seen;
        repeat (300) @(negedge clk);
        check(frames_seen == seen, "R7", "no extra frame", frames_seen, seen);
        check(mdio_oe == 1'b0, "R1", "output enable idle", mdio_oe, 0);
        check(exp_bits_q.size() == 0, "R3", "all frames observed", exp_bits_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule